// File: doc/BRIEF.md
# Big-Endian Sub-Word Lane Unit

This block places byte and halfword data inside a 32-bit memory word for a processor's load, store and register-extend operations. Sub-word data always lives in the most-significant lanes of the word: a byte occupies the top eight bits and a halfword the top sixteen. No address bits choose a lane.

A load takes a fetched word and returns the register value, zero-filled or sign-filled as the size code asks. A store takes the old memory word and the register data and returns the merged word to write back. An extend operation widens the low byte or low halfword of a register value in place. Each accepted request produces one registered result one clock later, flagged by an output strobe.

Top module: `lane_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid becomes 0 and result becomes 0 after that edge (synchronous reset).
- R2: A request with in_valid high at a rising edge gives out_valid high and its result after that same edge. With in_valid low, out_valid is low after the edge and result keeps its previous value.
- R3: Encodings are as follows. op_kind 00 is load, 01 is store, and 10 or 11 is extend. size_code[1:0] 00 is byte, 01 is halfword, and 10 or 11 is word. size_code[2] = 1 selects sign extension.
- R4: A byte load returns mem_word[31:24] in result[7:0]. Bits 31:8 are copies of mem_word[31] when signed and zero when unsigned.
- R5: A halfword load returns mem_word[31:16] in result[15:0]. Bits 31:16 are copies of mem_word[31] when signed and zero when unsigned.
- R6: A byte store returns reg_data[7:0] in bits 31:24 and mem_word[23:0] in bits 23:0.
- R7: A halfword store returns reg_data[15:0] in bits 31:16 and mem_word[15:0] in bits 15:0.
- R8: A word load returns mem_word unchanged. A word store returns reg_data unchanged. The sign bit has no effect on either.
- R9: An extend operation works on reg_data and ignores mem_word. For a byte it fills bits 31:8 with bit 7 when signed and with zero when unsigned. For a halfword it fills bits 31:16 with bit 15 when signed and with zero when unsigned. For a word it returns reg_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_kind | input | 2 | Operation: load, store or extend |
| size_code | input | 3 | Access size in bits 1:0, signed flag in bit 2 |
| mem_word | input | 32 | Fetched word for a load, old word for a store |
| reg_data | input | 32 | Register data for a store or an extend |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 32 | Register value or merged memory word |

## Verification
Every top-lane byte value is swept through every operation and every size code. This covers the 0x7F/0x80 sign boundary, so a design that tapped the wrong sign bit would fill the upper bits wrongly on half of the patterns. The bytes below the active lane are random. A store that took its lane from the low end, or that cleared the kept bits, would therefore produce mismatching low bits. Word sizes are driven with the sign flag both set and clear, which exposes a design that sign-fills full-width accesses. Idle cycles change both data inputs, which catches a result register that loads when no request is present.

// File: rtl/lane_pkg.sv
// Shared encodings for the sub-word lane unit.
// Assumes callers cast raw two-bit port fields into these types.
package lane_pkg;
    typedef enum logic [1:0] {
        OPK_LOAD    = 2'b00,
        OPK_STORE   = 2'b01,
        OPK_EXTEND  = 2'b10,
        OPK_EXTEND2 = 2'b11
    } op_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } size_e;
endpackage

// File: rtl/lane_extend.sv
// Widens a right-aligned byte or halfword to the full word, with sign or zero fill.
// Assumes the value sits in the low bits; word size passes it through unchanged.
module lane_extend
    import lane_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [WORD_W-1:0] val_in,
    input  size_e             size,
    input  logic              sign_en,
    output logic [WORD_W-1:0] val_out
);
    localparam int HALF_W = 2 * LANE_W;

    logic fill_b;
    logic fill_h;

    // Pick the fill bit for each narrow size.
    always_comb begin
        fill_b = sign_en & val_in[LANE_W-1];
        fill_h = sign_en & val_in[HALF_W-1];
    end

    // Apply the fill above the selected width.
    always_comb begin
        unique case (size)
            SZ_BYTE: val_out = {{(WORD_W-LANE_W){fill_b}}, val_in[LANE_W-1:0]};
            SZ_HALF: val_out = {{(WORD_W-HALF_W){fill_h}}, val_in[HALF_W-1:0]};
            SZ_WORD, SZ_WORD2: val_out = val_in;
        endcase
    end
endmodule

// File: rtl/lane_load_select.sv
// Moves the most-significant byte or halfword lane of a memory word to the low bits.
// Assumes big-endian placement: sub-word data is always in the top lanes.
module lane_load_select
    import lane_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [WORD_W-1:0] mem_in,
    input  size_e             size,
    output logic [WORD_W-1:0] aligned
);
    localparam int HALF_W = 2 * LANE_W;

    // Right-align the top lane(s) and zero the rest.
    always_comb begin
        unique case (size)
            SZ_BYTE: aligned = {{(WORD_W-LANE_W){1'b0}}, mem_in[WORD_W-1 -: LANE_W]};
            SZ_HALF: aligned = {{(WORD_W-HALF_W){1'b0}}, mem_in[WORD_W-1 -: HALF_W]};
            SZ_WORD, SZ_WORD2: aligned = mem_in;
        endcase
    end
endmodule

// File: rtl/lane_store_merge.sv
// Writes the low bits of register data into the top lane(s) of the old memory word.
// Assumes big-endian placement; the lower lanes of the old word are kept.
module lane_store_merge
    import lane_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] wr_data,
    input  size_e             size,
    output logic [WORD_W-1:0] merged
);
    localparam int HALF_W = 2 * LANE_W;

    // Merge new top lane(s) with the kept low part of the old word.
    always_comb begin
        unique case (size)
            SZ_BYTE: merged = {wr_data[LANE_W-1:0], old_word[WORD_W-LANE_W-1:0]};
            SZ_HALF: merged = {wr_data[HALF_W-1:0], old_word[WORD_W-HALF_W-1:0]};
            SZ_WORD, SZ_WORD2: merged = wr_data;
        endcase
    end
endmodule

// File: rtl/lane_unit.sv
// Big-endian sub-word lane unit: load alignment, store merge and register extend.
// The result is registered with one cycle of latency. Assumes no alignment checks here.
module lane_unit
    import lane_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_kind,
    input  logic [2:0]        size_code,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] reg_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    localparam int HALF_W = 2 * LANE_W;

    op_kind_e          kind;
    size_e             size;
    logic              sign_en;
    logic [WORD_W-1:0] ld_aligned;
    logic [WORD_W-1:0] ext_src;
    logic [WORD_W-1:0] ext_val;
    logic [WORD_W-1:0] st_val;
    logic [WORD_W-1:0] next_val;

    // Decode the raw control fields.
    always_comb begin
        kind    = op_kind_e'(op_kind);
        size    = size_e'(size_code[1:0]);
        sign_en = size_code[2];
    end

    lane_load_select #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_ldsel (
        .mem_in  (mem_word),
        .size    (size),
        .aligned (ld_aligned)
    );

    lane_store_merge #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_stmerge (
        .old_word (mem_word),
        .wr_data  (reg_data),
        .size     (size),
        .merged   (st_val)
    );

    // Feed the shared extender from memory for loads, from the register otherwise.
    always_comb begin
        ext_src = (kind == OPK_LOAD) ? ld_aligned : reg_data;
    end

    lane_extend #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_ext (
        .val_in  (ext_src),
        .size    (size),
        .sign_en (sign_en),
        .val_out (ext_val)
    );

    // Choose the result for the operation.
    always_comb begin
        next_val = (kind == OPK_STORE) ? st_val : ext_val;
    end

    // Register the result and strobe; hold the result while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_val;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R4
    byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'b00 && size_code == 3'b000)
        |=> (result[WORD_W-1:LANE_W] == '0));

    // R6
    byte_store_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'b01 && size_code[1:0] == 2'b00)
        |=> (result[WORD_W-LANE_W-1:0] == $past(mem_word[WORD_W-LANE_W-1:0])));

    // R7
    half_store_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'b01 && size_code[1:0] == 2'b01)
        |=> (result[WORD_W-HALF_W-1:0] == $past(mem_word[WORD_W-HALF_W-1:0])));

    // R8
    word_load_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'b00 && size_code[1])
        |=> (result == $past(mem_word)));

    // R9
    byte_sext_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind[1] && size_code == 3'b100)
        |=> ($countones(result[WORD_W-1:LANE_W-1]) == 0 ||
             $countones(result[WORD_W-1:LANE_W-1]) == WORD_W - LANE_W + 1));
endmodule

// File: tb/tb_lane_unit.sv
module tb_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [2:0]  size_code = 3'b000;
    logic [31:0] mem_word = '0;
    logic [31:0] reg_data = '0;
    logic        out_valid;
    logic [31:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic [31:0] rnd = 32'h1234_5678;

    lane_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
        .size_code(size_code), .mem_word(mem_word), .reg_data(reg_data),
        .out_valid(out_valid), .result(result)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] next_rnd(logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Expected value from the requirement arithmetic (R3..R9).
    function automatic logic [31:0] expect_val(logic [1:0] op, logic [2:0] sz,
                                               logic [31:0] m, logic [31:0] r);
        longint mv = longint'(m);
        longint rv = longint'(r);
        longint v;
        bit     sg = sz[2];
        logic [31:0] t;
        if (op == 2'b01) begin
            if (sz[1]) v = rv;
            else if (sz[0]) v = (rv % 65536) * 65536 + (mv % 65536);
            else v = (rv % 256) * 16777216 + (mv % 16777216);
        end else begin
            longint src = (op == 2'b00) ? mv : rv;
            if (sz[1]) v = src;
            else if (sz[0]) begin
                v = (op == 2'b00) ? src / 65536 : src % 65536;
                if (sg && v >= 32768) v = v - 65536;
            end else begin
                v = (op == 2'b00) ? src / 16777216 : src % 256;
                if (sg && v >= 128) v = v - 256;
            end
        end
        t = v[31:0];
        return t;
    endfunction

    function automatic string tag_of(logic [1:0] op, logic [2:0] sz);
        if (op[1]) return "R3 R9";
        if (sz[1]) return "R3 R8";
        if (op == 2'b01) return sz[0] ? "R3 R7" : "R3 R6";
        return sz[0] ? "R3 R5" : "R3 R4";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        logic [31:0] ex;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        rst_n = 1'b1;

        // R3 encodings swept: every op, every size code, every top-lane byte
        for (int op = 0; op < 4; op++) begin
            for (int sz = 0; sz < 8; sz++) begin
                for (int b = 0; b < 256; b++) begin
                    @(negedge clk);
                    rnd = next_rnd(rnd);
                    mem_word = {b[7:0], rnd[23:0]};
                    rnd = next_rnd(rnd);
                    reg_data = {rnd[31:8], b[7:0]};
                    op_kind = op[1:0];
                    size_code = sz[2:0];
                    in_valid = 1'b1;
                    ex = expect_val(op[1:0], sz[2:0], mem_word, reg_data);
                    @(negedge clk);
                    check("R2 out_valid", {31'b0, out_valid}, 32'd1);
                    check(tag_of(op[1:0], sz[2:0]), result, ex);
                end
            end
        end

        // R2: idle cycles hold result even when data inputs change
        held = result;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            rnd = next_rnd(rnd);
            mem_word = rnd;
            reg_data = ~rnd;
            op_kind = rnd[1:0];
            size_code = rnd[4:2];
            @(negedge clk);
            check("R2 idle out_valid", {31'b0, out_valid}, 32'd0);
            check("R2 idle hold", result, held);
        end

        finish_run();
    end
endmodule